// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Synthesizer

This block is a direct digital synthesizer that emits one signed sine sample and one signed cosine sample per clock. A wide phase register adds a programmable tuning word on every enabled clock. A separate phase offset is then added to that running phase, and the sum is cut down to a short phase index. A table holding only one quarter of a sine period turns the index into an amplitude. The sign and the mirror symmetry of the wave supply the other three quarters. The output frequency is the clock frequency times the tuning word, divided by 2 to the power of the accumulator width.

The top two bits of the phase index name the quadrant, and the datapath treats each quadrant as a named state. In `Q_RISE` (00) the table is read directly and the output stays positive. In `Q_FALL` (01) the address is mirrored and the output stays positive. In `Q_DIP` (10) the address is read directly and the output is negated. In `Q_CLIMB` (11) the address is mirrored and the output is negated. As the phase advances, the quadrant moves through the transitions `Q_RISE -> Q_FALL -> Q_DIP -> Q_CLIMB -> Q_RISE`. A negative tuning word runs the same ring backwards. The cosine channel is the sine channel advanced by one quadrant: it reads a second port of the same table.

A sample takes two registered stages: a table read, then conditional negation. The valid flag passes through the same two stages as the enable.

Top module: `sincos_dds`

## Requirements
- R1: While `rst` is high at a rising edge, the phase register is cleared to zero. The outputs read zero and `sample_vld` is low from the following edge on.
- R2: Sample n after reset uses the phase (n × `tune_word` + `phase_ofs`) modulo 2^32. A tuning word with the top bits set steps the phase backwards and wraps through zero.
- R3: The phase offset is added after the phase register and is never stored in it. Changing `phase_ofs` moves only the samples captured after the change, and the accumulated phase continues undisturbed.
- R4: The phase index p is bits 31:20 of the offset phase. Carries from the discarded low bits build up, so a step of 2^19 advances p once every two samples.
- R5: `sine_out` equals the rounded value of 32767 × sin(2π(p + 0.5)/4096), to within 1 LSB, in 16-bit two's complement.
- R6: Bit 11 of p selects the negative half and bit 10 selects the mirrored quarter, where the table address is the ones' complement of bits 9:0. The sample at p + 2048 is the exact negation of the sample at p.
- R7: `cosine_out` equals the R5 value for the index p + 1024 modulo 4096, computed in the same cycle as the sine.
- R8: While `en` is low, the phase register holds its value. After `en` returns, the next sample continues from the held phase and no phase step is lost.
- R9: `sample_vld` rises exactly two rising edges after the edge that captures an enabled phase, and falls two edges after `en` falls. While it is low, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the phase and launches a sample |
| tune_word | input | 32 | Phase step added per enabled clock |
| phase_ofs | input | 32 | Phase offset added before the lookup |
| sine_out | output | 16 | Signed sine sample |
| cosine_out | output | 16 | Signed cosine sample |
| sample_vld | output | 1 | Marks `sine_out` and `cosine_out` as valid |

## Verification
The hardest cases to reach are the quadrant seams. Those are the indices 1023/1024, 2047/2048 and 3071/3072, and the wrap from 4095 to 0. There the mirrored address swings between 0 and 1023 and the sign flips. A free-running tuning word only lands on them by chance. To reach them, the stimulus sets the tuning word to zero and places the phase with the offset alone. It then compares each seam index against its partner half a turn away and requires exact negation. A second scenario switches the offset during a run. This shows that the accumulated phase carries on unchanged. A third scenario drops enable for several cycles in the middle of a stream to check the hold and the two-cycle valid latency.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Quadrant of the phase index: named by the shape of the sine in it.
    typedef enum logic [1:0] {
        Q_RISE  = 2'b00,
        Q_FALL  = 2'b01,
        Q_DIP   = 2'b10,
        Q_CLIMB = 2'b11
    } quad_e;

    // pi in Q30 fixed point
    localparam longint PI_Q30 = 64'sd3373259426;

    // Magnitude of sin at the half-step point (k + 0.5) of a quarter period
    // split into 2**addr_w steps, scaled to 2**(out_w-1)-1 and rounded.
    function automatic int qsin_mag(input int k, input int addr_w, input int out_w);
        longint x;
        longint x2;
        longint term;
        longint sum;
        longint amp;
        longint res;
        x    = (PI_Q30 * longint'(2 * k + 1)) >>> (addr_w + 2);
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int i = 1; i < 10; i++) begin
            term = -((term * x2) >>> 30) / longint'((2 * i) * (2 * i + 1));
            sum  = sum + term;
        end
        amp = (longint'(1) <<< (out_w - 1)) - 1;
        res = (sum * amp + (longint'(1) <<< 29)) >>> 30;
        if (res > amp) res = amp;
        if (res < 0)   res = 0;
        return int'(res);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] tune_word,
    input  logic [ACC_W-1:0] phase_ofs,
    output logic [PH_W-1:0]  phase_idx
);

    localparam int DROP = ACC_W - PH_W;

    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_q + tune_word;
        end
    end

    // Offset joins after the register; only the top bits survive.
    assign phase_idx = PH_W'((acc_q + phase_ofs) >> DROP);

    p_clear_r1: assert property (@(posedge clk) rst |=> acc_q == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> acc_q == $past(acc_q) + $past(tune_word));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> acc_q == $past(acc_q));

endmodule

// File: rtl/dds_addr_fold.sv
module dds_addr_fold
    import dds_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int QTURN  = 0
) (
    input  logic [ADDR_W+1:0] phase_idx,
    output quad_e             quad,
    output logic [ADDR_W-1:0] addr
);

    localparam int PH_W = ADDR_W + 2;
    localparam logic [PH_W-1:0] SHIFT = PH_W'(QTURN) << ADDR_W;

    logic [PH_W-1:0] ph;

    always_comb begin
        ph   = phase_idx + SHIFT;
        quad = quad_e'(ph[PH_W-1 -: 2]);
        unique case (quad)
            Q_RISE, Q_DIP:   addr = ph[ADDR_W-1:0];
            Q_FALL, Q_CLIMB: addr = ~ph[ADDR_W-1:0];
        endcase
    end

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
    parameter int ADDR_W = 10,
    parameter int OUT_W  = 16,
    parameter int NPORT  = 2
) (
    input  logic                          clk,
    input  logic [NPORT-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NPORT-1:0][OUT_W-2:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int MAG_W = OUT_W - 1;

    logic [MAG_W-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
        assign tbl[k] = MAG_W'(dds_pkg::qsin_mag(k, ADDR_W, OUT_W));
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            rd_data[p] <= tbl[rd_addr[p]];
        end
    end

endmodule

// File: rtl/dds_sign_stage.sv
module dds_sign_stage
    import dds_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    v_in,
    input  quad_e                   quad,
    input  logic [OUT_W-2:0]        mag,
    output logic signed [OUT_W-1:0] smp_q
);

    logic signed [OUT_W-1:0] pos;
    logic signed [OUT_W-1:0] smp_d;

    always_comb begin
        pos = signed'({1'b0, mag});
        unique case (quad)
            Q_RISE, Q_FALL:  smp_d = pos;
            Q_DIP, Q_CLIMB:  smp_d = -pos;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !v_in) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    p_neg_half_r6: assert property (@(posedge clk) disable iff (rst)
        (v_in && quad[1]) |=> smp_q <= 0);

    p_pos_half_r6: assert property (@(posedge clk) disable iff (rst)
        (v_in && !quad[1]) |=> smp_q >= 0);

endmodule

// File: rtl/sincos_dds.sv
module sincos_dds
    import dds_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 10,
    parameter int OUT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [ACC_W-1:0]        tune_word,
    input  logic [ACC_W-1:0]        phase_ofs,
    output logic signed [OUT_W-1:0] sine_out,
    output logic signed [OUT_W-1:0] cosine_out,
    output logic                    sample_vld
);

    localparam int PH_W  = ADDR_W + 2;
    localparam int NCH   = 2;
    localparam int MAG_W = OUT_W - 1;

    logic [PH_W-1:0]               phase_idx;
    logic [NCH-1:0][ADDR_W-1:0]    rd_addr;
    logic [NCH-1:0][MAG_W-1:0]     rd_data;
    quad_e                         quad_c  [NCH];
    quad_e                         quad_s1 [NCH];
    logic signed [OUT_W-1:0]       smp     [NCH];
    logic                          v_s1;

    dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tune_word (tune_word),
        .phase_ofs (phase_ofs),
        .phase_idx (phase_idx)
    );

    dds_quarter_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .NPORT(NCH)) u_rom (
        .clk     (clk),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Channel 0 is the sine, channel 1 the cosine (one quadrant ahead).
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [ADDR_W-1:0] addr_c;

        dds_addr_fold #(.ADDR_W(ADDR_W), .QTURN(ch)) u_fold (
            .phase_idx (phase_idx),
            .quad      (quad_c[ch]),
            .addr      (addr_c)
        );

        assign rd_addr[ch] = addr_c;

        always_ff @(posedge clk) begin
            quad_s1[ch] <= quad_c[ch];
        end

        dds_sign_stage #(.OUT_W(OUT_W)) u_sign (
            .clk   (clk),
            .rst   (rst),
            .v_in  (v_s1),
            .quad  (quad_s1[ch]),
            .mag   (rd_data[ch]),
            .smp_q (smp[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_s1       <= 1'b0;
            sample_vld <= 1'b0;
        end else begin
            v_s1       <= en;
            sample_vld <= v_s1;
        end
    end

    assign sine_out   = smp[0];
    assign cosine_out = smp[1];

    p_vld_rise_r9: assert property (@(posedge clk) disable iff (rst)
        v_s1 |=> sample_vld);

    p_vld_fall_r9: assert property (@(posedge clk) disable iff (rst)
        !v_s1 |=> !sample_vld);

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !sample_vld |-> (sine_out == 0 && cosine_out == 0));

    p_cos_lead_r7: assert property (@(posedge clk) disable iff (rst)
        (quad_c[0] == Q_RISE) |-> (quad_c[1] == Q_FALL));

endmodule

// File: tb/sincos_dds_bench.sv
module sincos_dds_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [31:0]        tune_word = '0;
    logic [31:0]        phase_ofs = '0;
    logic signed [15:0] sine_out;
    logic signed [15:0] cosine_out;
    logic               sample_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sincos_dds u_sincos_dds (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tune_word  (tune_word),
        .phase_ofs  (phase_ofs),
        .sine_out   (sine_out),
        .cosine_out (cosine_out),
        .sample_vld (sample_vld)
    );

    function automatic int ref_val(input int p);
        real ang;
        real m;
        ang = 2.0 * 3.14159265358979 * (real'(p & 4095) + 0.5) / 4096.0;
        m   = $sin(ang) * 32767.0;
        if (m >= 0.0) return $rtoi(m + 0.5);
        return -$rtoi(-m + 0.5);
    endfunction

    task automatic chk_eq(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_near(input int act, input int exp, input string req);
        checks++;
        if (act > exp + 1 || act < exp - 1) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (+/-1)", req, act, exp);
        end
    endtask

    // Compare the current outputs against sample n of a stream.
    task automatic chk_sample(input int n, input logic [31:0] tw,
                              input logic [31:0] off, input string req);
        logic [31:0] ph;
        int p;
        ph = tw * 32'(n) + off;
        p  = int'(ph[31:20]);
        chk_eq(int'(sample_vld), 1, {req, " valid"});
        chk_near(int'(sine_out), ref_val(p), {req, " R5 sine"});
        chk_near(int'(cosine_out), ref_val(p + 1024), {req, " R7 cosine"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Free-running stream; the offset switches to off_b from sample sw on.
    task automatic run_stream(input logic [31:0] tw, input logic [31:0] off_a,
                              input logic [31:0] off_b, input int sw,
                              input int cnt, input string req);
        do_reset();
        tune_word = tw;
        phase_ofs = off_a;
        en        = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_eq(int'(sample_vld), 0, {req, " R9 latency"});
        @(posedge clk);
        for (int n = 0; n < cnt; n++) begin
            @(negedge clk);
            chk_sample(n, tw, (n >= sw) ? off_b : off_a, req);
            if (n + 2 == sw) phase_ofs = off_b;
            @(posedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk_eq(int'(sample_vld), 0, "R1 valid after reset");
        chk_eq(int'(sine_out), 0, "R1 sine after reset");
        chk_eq(int'(cosine_out), 0, "R1 cosine after reset");
    endtask

    task automatic t_unit_step();
        run_stream(32'h0010_0000, 32'h0, 32'h0, 1000, 24, "R2 unit step");
    endtask

    task automatic t_fraction_step();
        run_stream(32'h0A3D_70A4, 32'h0, 32'h0, 1000, 40, "R4 fractional step");
    endtask

    task automatic t_half_step();
        run_stream(32'h0008_0000, 32'h0, 32'h0, 1000, 12, "R4 half step");
    endtask

    task automatic t_backward();
        run_stream(32'hFFF0_0000, 32'h0, 32'h0, 1000, 12, "R2 backward wrap");
    endtask

    task automatic t_offset_switch();
        run_stream(32'h0070_0000, 32'h4000_0000, 32'h0, 6, 14, "R3 offset switch");
    endtask

    // Static phase placed by the offset only.
    task automatic probe(input int p, output int s, output int c);
        do_reset();
        tune_word = '0;
        phase_ofs = 32'(p) << 20;
        en        = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        s = int'(sine_out);
        c = int'(cosine_out);
    endtask

    task automatic t_seams();
        int seam [4] = '{0, 1023, 1024, 2047};
        int sa, ca, sb, cb;
        foreach (seam[i]) begin
            probe(seam[i], sa, ca);
            probe(seam[i] + 2048, sb, cb);
            chk_near(sa, ref_val(seam[i]), "R6 seam sine");
            chk_near(ca, ref_val(seam[i] + 1024), "R7 seam cosine");
            chk_near(sb, ref_val(seam[i] + 2048), "R6 seam sine far half");
            chk_eq(sb, -sa, "R6 half-turn negation sine");
            chk_eq(cb, -ca, "R6 half-turn negation cosine");
        end
        probe(4095, sa, ca);
        chk_near(sa, ref_val(4095), "R6 wrap index sine");
        chk_near(ca, ref_val(4095 + 1024), "R7 wrap index cosine");
    endtask

    task automatic t_enable_hold();
        logic [31:0] tw;
        tw = 32'h0050_0000;
        do_reset();
        tune_word = tw;
        phase_ofs = '0;
        en        = 1'b1;
        repeat (2) @(posedge clk);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk_sample(n, tw, 32'h0, "R8 before pause");
            if (n == 3) en = 1'b0;
            @(posedge clk);
        end
        @(negedge clk);
        chk_sample(4, tw, 32'h0, "R9 last in-flight sample");
        @(posedge clk);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk_eq(int'(sample_vld), 0, "R9 valid low in pause");
            chk_eq(int'(sine_out), 0, "R9 sine zero in pause");
            if (j == 2) en = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        chk_eq(int'(sample_vld), 0, "R9 latency on resume");
        @(posedge clk);
        for (int n = 5; n < 9; n++) begin
            @(negedge clk);
            chk_sample(n, tw, 32'h0, "R8 after pause");
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_unit_step();
        t_fraction_step();
        t_half_step();
        t_backward();
        t_offset_switch();
        t_seams();
        t_enable_hold();
        t_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule